// File: doc/BRIEF.md
# Vertical Six-Tap Luma Interpolator

This block produces the vertical half-sample interpolation of an 8-bit luma block. A one-cycle start pulse loads a width code and a height code. Source rows then stream in from top to bottom, one pixel row per accepted input beat. The first row supplied lies two rows above the first row to be predicted. The block keeps the five most recent rows. Each newly accepted row completes a six-row window. For every pixel column the block applies the symmetric taps 1, -5, 20, 20, -5, 1 from top to bottom. It adds 16, shifts arithmetically right by 5 and clamps to 0..255. The result is one output row.

Both streams use valid/ready. A beat transfers on a rising edge where valid and ready are both high. The output row is held in a single register. While that register is occupied and the consumer holds `out_ready` low, `in_ready` stays low. The held row and `out_valid` stay unchanged until it is taken. `in_ready` may depend on `out_ready` in the same cycle, so a row can be accepted in the same cycle the pending output leaves. `in_valid` must not depend on `in_ready`.

Top module: `vsix_interp`

## Requirements
- R1: Output row y, counted from 0, takes accepted source rows y..y+5. Lane l (bits 8l+7..8l) of each output equals a+f - 5(b+e) + 20(c+d), where a..f are lane l of those six rows from top to bottom.
- R2: Each lane sum is rounded by adding 16, shifted arithmetically right by 5, and clamped to 0..255. Negative sums give 0 and sums above the range give 255.
- R3: The width code (`cfg_width`) and the height code (`cfg_height`) are sampled at an accepted start. Code 0 selects 4, code 1 selects 8, and codes 2 and 3 select 16 (pixels or rows).
- R4: Lanes at or beyond the configured width are 0 in every output row.
- R5: A block accepts exactly H+5 source rows. `in_ready` is low when idle and after the H+5th row.
- R6: `out_valid` first rises in the cycle after the sixth source row is accepted. Each later accepted row yields one output row, and exactly H rows are emitted.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_row` and `out_valid` hold their values.
- R8: `done` is high for exactly one cycle, the cycle after the last output row is accepted. `busy` is low from that cycle on.
- R9: A start pulse while `busy` is high is ignored. The block in progress keeps its configuration and its results.
- R10: After reset `busy`, `done`, `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block when idle |
| cfg_width | input | 2 | Width code (0:4, 1:8, else 16) |
| cfg_height | input | 2 | Height code (0:4, 1:8, else 16) |
| in_valid | input | 1 | Source row is offered |
| in_ready | output | 1 | Source row can be accepted |
| in_row | input | 128 | Source row, lane l at bits 8l+7..8l |
| out_valid | output | 1 | Filtered row is offered |
| out_ready | input | 1 | Consumer accepts the filtered row |
| out_row | output | 128 | Filtered row, same lane layout |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-cycle pulse after the last output |

## Verification
The bench sweeps every width and height code, including the illegal code 3. It uses random pixels and row patterns that drive the weighted sum to its largest positive and most negative values. A design that wraps the intermediate sum, or that clamps without first rounding, gives visibly wrong pixels on those patterns. Random stalls on both streams expose a design that drops or duplicates a row under back-pressure, and a design that emits a row before its window is full. Each block ends with checks on the row counts and on the exact cycle of `done`. A start pulse issued mid-block would, if obeyed, shrink the block and corrupt the remaining rows.

// File: rtl/vsix_pkg.sv
package vsix_pkg;
  localparam int unsigned TAPS = 6;

  // Map a 2-bit size code onto a count: 0 -> quarter, 1 -> half, else full.
  function automatic int unsigned span_of(input logic [1:0] code, input int unsigned full);
    case (code)
      2'd0:    return full / 4;
      2'd1:    return full / 2;
      default: return full;
    endcase
  endfunction
endpackage

// File: rtl/vsix_tap.sv
module vsix_tap #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] p0,
  input  logic [PIX_W-1:0] p1,
  input  logic [PIX_W-1:0] p2,
  input  logic [PIX_W-1:0] p3,
  input  logic [PIX_W-1:0] p4,
  input  logic [PIX_W-1:0] p5,
  output logic [PIX_W-1:0] q
);
  localparam int ACC_W = PIX_W + 8;
  localparam logic signed [ACC_W-1:0] K5   = ACC_W'(5);
  localparam logic signed [ACC_W-1:0] K20  = ACC_W'(20);
  localparam logic signed [ACC_W-1:0] KRND = ACC_W'(16);
  localparam logic signed [ACC_W-1:0] KMAX = ACC_W'((1 << PIX_W) - 1);

  function automatic logic signed [ACC_W-1:0] ext(input logic [PIX_W-1:0] v);
    return $signed({{(ACC_W-PIX_W){1'b0}}, v});
  endfunction

  logic signed [ACC_W-1:0] sum, shifted;

  always_comb begin
    sum     = ext(p0) + ext(p5) - K5 * (ext(p1) + ext(p4)) + K20 * (ext(p2) + ext(p3)) + KRND;
    shifted = sum >>> 5;
    if (shifted < 0)         q = '0;
    else if (shifted > KMAX) q = '1;
    else                     q = shifted[PIX_W-1:0];
  end
endmodule

// File: rtl/vsix_window.sv
module vsix_window #(
  parameter int ROW_W = 128,
  parameter int DEPTH = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        shift,
  input  logic [ROW_W-1:0]            din,
  output logic [DEPTH-1:0][ROW_W-1:0] rows
);
  // rows[0] is the oldest (top) row, rows[DEPTH-1] the newest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rows[i] <= '0;
      else if (shift) rows[i] <= (i == DEPTH - 1) ? din : rows[(i + 1) % DEPTH];
    end
  end
endmodule

// File: rtl/vsix_ctrl.sv
module vsix_ctrl
  import vsix_pkg::*;
#(
  parameter int LANES = 16,
  parameter int MAX_H = 16,
  parameter int CNT_W = 5,
  parameter int LW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_width,
  input  logic [1:0]       cfg_height,
  input  logic             in_fire,
  input  logic             out_fire,
  output logic             busy,
  output logic             done,
  output logic             room,
  output logic             emit,
  output logic [LANES-1:0] lane_en
);
  logic [LW-1:0]    width_q;
  logic [CNT_W-1:0] height_q, in_cnt, out_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      width_q  <= '0;
      height_q <= '0;
      in_cnt   <= '0;
      out_cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        width_q  <= LW'(span_of(cfg_width, LANES));
        height_q <= CNT_W'(span_of(cfg_height, MAX_H));
        in_cnt   <= '0;
        out_cnt  <= '0;
      end else if (busy) begin
        if (in_fire) in_cnt <= in_cnt + CNT_W'(1);
        if (out_fire) begin
          out_cnt <= out_cnt + CNT_W'(1);
          if (out_cnt == height_q - CNT_W'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign room = in_cnt < (height_q + CNT_W'(TAPS - 1));
  assign emit = in_fire && (in_cnt >= CNT_W'(TAPS - 1));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_en
    assign lane_en[l] = LW'(l) < width_q;
  end
endmodule

// File: rtl/vsix_interp.sv
module vsix_interp
  import vsix_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 16,
  parameter int MAX_H = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [1:0]             cfg_width,
  input  logic [1:0]             cfg_height,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_row,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*PIX_W-1:0] out_row,
  output logic                   busy,
  output logic                   done
);
  localparam int ROW_W = LANES * PIX_W;
  localparam int CNT_W = $clog2(MAX_H + TAPS);
  localparam int LW    = $clog2(LANES + 1);

  logic in_fire, out_fire, room, emit;
  logic [LANES-1:0] lane_en;
  logic [TAPS-2:0][ROW_W-1:0] win;
  logic [ROW_W-1:0] filt, masked;

  assign in_ready = busy && room && (!out_valid || out_ready);
  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  vsix_ctrl #(.LANES(LANES), .MAX_H(MAX_H), .CNT_W(CNT_W), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_fire(in_fire), .out_fire(out_fire), .busy(busy), .done(done),
    .room(room), .emit(emit), .lane_en(lane_en)
  );

  vsix_window #(.ROW_W(ROW_W), .DEPTH(TAPS - 1)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(in_fire), .din(in_row), .rows(win)
  );

  // The incoming row is the bottom tap; the window supplies the five above it.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vsix_tap #(.PIX_W(PIX_W)) u_tap (
      .p0(win[0][l*PIX_W +: PIX_W]), .p1(win[1][l*PIX_W +: PIX_W]),
      .p2(win[2][l*PIX_W +: PIX_W]), .p3(win[3][l*PIX_W +: PIX_W]),
      .p4(win[4][l*PIX_W +: PIX_W]), .p5(in_row[l*PIX_W +: PIX_W]),
      .q(filt[l*PIX_W +: PIX_W])
    );
    assign masked[l*PIX_W +: PIX_W] = lane_en[l] ? filt[l*PIX_W +: PIX_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_row   <= masked;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vsix_interp_chk.sv
module vsix_interp_chk
  import vsix_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LANES = 16,
  parameter int MAX_H = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic [1:0]             cfg_width,
  input logic [1:0]             cfg_height,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*PIX_W-1:0] out_row,
  input logic                   busy,
  input logic                   done
);
  localparam int ROW_W = LANES * PIX_W;
  localparam int CNT_W = $clog2(MAX_H + TAPS);
  localparam int LW    = $clog2(LANES + 1);

  logic [CNT_W-1:0] lat_h, acc_cnt;
  logic [LW-1:0]    lat_w;
  logic [ROW_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_h   <= '0;
      lat_w   <= '0;
      acc_cnt <= '0;
    end else if (start && !busy) begin
      lat_h   <= CNT_W'(span_of(cfg_height, MAX_H));
      lat_w   <= LW'(span_of(cfg_width, LANES));
      acc_cnt <= '0;
    end else if (in_valid && in_ready) begin
      acc_cnt <= acc_cnt + CNT_W'(1);
    end
  end

  always_comb begin
    for (int l = 0; l < LANES; l++)
      mask[l*PIX_W +: PIX_W] = (LW'(l) < lat_w) ? '1 : '0;
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_row)); // R7
  AST_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |-> acc_cnt < lat_h + CNT_W'(TAPS - 1)); // R5
  AST_IDLE_NO_IN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready); // R5
  AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_row & ~mask) == '0); // R4
  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_cnt >= CNT_W'(TAPS)); // R6
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(out_valid && out_ready) |=> busy); // R9
endmodule

bind vsix_interp vsix_interp_chk #(.PIX_W(PIX_W), .LANES(LANES), .MAX_H(MAX_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .cfg_height(cfg_height),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_row(out_row), .busy(busy), .done(done)
);

// File: tb/vsix_interp_tb.sv
`timescale 1ns/1ps
module vsix_interp_tb;
  localparam int ROW_W = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_width = '0, cfg_height = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [ROW_W-1:0] in_row = '0;
  logic in_ready, out_valid, busy, done;
  logic [ROW_W-1:0] out_row;

  int checks = 0, errors = 0;
  bit summarized = 1'b0;
  logic [ROW_W-1:0] src [0:20];

  always #2 clk = ~clk;

  vsix_interp u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_row(in_row),
    .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .busy(busy), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int decode(input int code);
    return (code == 0) ? 4 : (code == 1) ? 8 : 16;
  endfunction

  function automatic logic [7:0] pix(input int mode, input int r, input int l);
    case (mode)
      1: return ((r % 6) == 2 || (r % 6) == 3) ? 8'hFF : 8'h00;
      2: return ((r % 6) == 1 || (r % 6) == 4) ? 8'hFF : 8'h00;
      3: return 8'((r * 17 + l * 13) & 255);
      default: return 8'($urandom);
    endcase
  endfunction

  function automatic logic [ROW_W-1:0] expect_row(input int y, input int w);
    logic [ROW_W-1:0] e = '0;
    for (int l = 0; l < w; l++) begin
      int a = src[y][l*8 +: 8], b = src[y+1][l*8 +: 8], c = src[y+2][l*8 +: 8];
      int d = src[y+3][l*8 +: 8], f = src[y+4][l*8 +: 8], g = src[y+5][l*8 +: 8];
      int s = a + g - 5 * (b + f) + 20 * (c + d);
      s = (s + 16) >>> 5;
      if (s < 0) s = 0;
      if (s > 255) s = 255;
      e[l*8 +: 8] = 8'(s);
    end
    return e;
  endfunction

  task automatic run_block(input int wc, input int hc, input int mode, input bit bp, input bit poke);
    int w = decode(wc);
    int h = decode(hc);
    int nin = h + 5;
    int acc = 0, outs = 0, cyc = 0, last_out = -10;
    bit fin = 1'b0, seen_out = 1'b0;
    for (int r = 0; r < 21; r++)
      for (int l = 0; l < 16; l++) src[r][l*8 +: 8] = pix(mode, r, l);
    @(negedge clk);
    start = 1'b1; cfg_width = 2'(wc); cfg_height = 2'(hc);
    @(negedge clk);
    start = 1'b0;
    while (!fin && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      in_valid  = (acc < nin) && (!bp || ($urandom % 4 != 0));
      in_row    = (acc < nin) ? src[acc] : '0;
      out_ready = !bp || ($urandom % 3 != 0);
      if (poke && cyc == 8) begin
        start = 1'b1; cfg_width = 2'd0; cfg_height = 2'd0;   // R9: must be ignored
      end else begin
        start = 1'b0;
      end
      #1;
      if (done) begin
        check(cyc == last_out + 1, "R8 done one cycle after last output", ROW_W'(cyc), ROW_W'(last_out + 1));
        check(!busy, "R8 busy low with done", ROW_W'(busy), '0);
        check(outs == h, poke ? "R9 R3 R6 output row count" : "R3 R6 output row count", ROW_W'(outs), ROW_W'(h));
        check(acc == nin, "R5 accepted row count", ROW_W'(acc), ROW_W'(nin));
        fin = 1'b1;
      end
      if (acc >= nin && in_ready) check(1'b0, "R5 in_ready after last row", ROW_W'(in_ready), '0);
      if (out_valid && !seen_out) begin
        seen_out = 1'b1;
        check(acc == 6, "R6 first output after sixth row", ROW_W'(acc), ROW_W'(6));
      end
      if (out_valid && !out_ready && in_ready) check(1'b0, "R7 in_ready while stalled", ROW_W'(in_ready), '0);
      if (in_valid && in_ready) acc++;
      if (out_valid && out_ready) begin
        if (outs < h)
          check(out_row == expect_row(outs, w), poke ? "R9 R1 R2 R4 output row" : "R1 R2 R4 R3 output row",
                out_row, expect_row(outs, w));
        else
          check(1'b0, "R6 extra output row", out_row, '0);
        outs++;
        last_out = cyc;
      end
    end
    if (!fin) check(1'b0, "R8 no done pulse", ROW_W'(outs), ROW_W'(h));
    in_valid = 1'b0; start = 1'b0; out_ready = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); #1;
      check(!in_ready && !out_valid && !busy && !done, "R8 R5 idle after block",
            ROW_W'({in_ready, out_valid, busy, done}), '0);
    end
  endtask

  // Stall check on held output (R7): hold out_ready low and watch out_row.
  task automatic stall_block();
    logic [ROW_W-1:0] held;
    int acc = 0;
    for (int r = 0; r < 21; r++)
      for (int l = 0; l < 16; l++) src[r][l*8 +: 8] = pix(0, r, l);
    @(negedge clk);
    start = 1'b1; cfg_width = 2'd2; cfg_height = 2'd0;
    @(negedge clk);
    start = 1'b0; out_ready = 1'b0;
    while (!out_valid) begin
      in_valid = 1'b1; in_row = src[acc];
      #1;
      if (in_ready) acc++;
      @(negedge clk);
    end
    held = out_row;
    in_valid = 1'b1; in_row = src[acc];
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); #1;
      check(out_valid && out_row == held && !in_ready, "R7 held output under stall", out_row, held);
    end
    check(held == expect_row(0, 16), "R1 first row after stall", held, expect_row(0, 16));
    while (busy) begin
      @(negedge clk);
      in_valid = (acc < 9); in_row = (acc < 9) ? src[acc] : '0; out_ready = 1'b1;
      #1;
      if (in_valid && in_ready) acc++;
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, '0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !in_ready && !out_valid, "R10 reset state",
          ROW_W'({busy, done, in_ready, out_valid}), '0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!in_ready && !busy, "R10 R5 idle after reset", ROW_W'({in_ready, busy}), '0);
    for (int wc = 0; wc < 4; wc++)
      for (int hc = 0; hc < 4; hc++)
        run_block(wc, hc, (wc + hc) % 4, hc[0], 1'b0);
    run_block(2, 2, 1, 1'b0, 1'b0);
    run_block(2, 2, 2, 1'b1, 1'b0);
    run_block(1, 3, 0, 1'b1, 1'b1);
    run_block(2, 2, 3, 1'b0, 1'b1);
    run_block(3, 3, 0, 1'b1, 1'b0);
    stall_block();
    summary();
  end
endmodule